// File: doc/BRIEF.md
# Key-Protected DRAM Configuration Register Bank

This block holds the configuration and status words of a DRAM controller behind a 32-bit memory-mapped read/write port in a 4 KB window. A write to word 0 (the lock word) opens the bank only if the data equals the unlock key 0xFC600309. Any other value written there closes it. While the bank is closed, every write aimed at another word is dropped. Reads are never blocked.

The configuration word at byte offset 0x004 keeps a set of protected fields. On every accepted write, the protected bits are taken out of the write data and a constant pattern is merged in. That constant carries the installed memory size code. A `VARIANT` parameter selects between two layouts. It sets the protected mask, the constant pattern and the size encoding. In variant B, two status words also report success however software writes them. Reads come straight from storage with no added latency. A write lands on the clock edge where the write strobe is high.

Top module: `dramcfg_keyed_regs`

## Requirements
- R1: A write of exactly 0xFC600309 to byte offset 0x000 makes the lock word read back as 0x00000001. The next write to any other in-range word is then stored.
- R2: A write of any other value to offset 0x000 makes the lock word read 0x00000000, which closes the bank again.
- R3: While the lock word reads 0, writes to every offset other than 0x000 leave all readable words unchanged, including the configuration word.
- R4: An accepted write to offset 0x004 stores (data AND NOT mask) OR pattern. Variant A uses mask 0xFFFFF84C and pattern 0x00000040 OR size code. Variant B uses mask 0xF00FC04C and pattern 0x1008000C OR size code. The size code sits in bits 1:0.
- R5: After a synchronous active-low reset, every word reads 0 except the configuration word, which reads the variant's pattern.
- R6: In variant B, an accepted write to offset 0x060 always stores bit 0 as 0.
- R7: In variant B, an accepted write to offset 0x070 always stores bit 12 as 1 and bit 13 as 0.
- R8: Word indices at or above `NUM_REGS` (32 by default, so byte offsets 0x080 to 0xFFC) read as zero, and writes to them change nothing.
- R9: The size code depends on the variant. Variant A maps 64, 128, 256 and 512 MB to 0, 1, 2 and 3, and any other size to 2. Variant B maps 128, 256, 512 and 1024 MB to 0, 1, 2 and 3, and any other size to 2.
- R10: Address bits 1:0 are ignored, so a write to 0x017 updates the word at 0x014.
- R11: Words with no special rule store the written data unchanged on the write edge. Reads return the stored value combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address inside the window |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The hardest states to reach are the ones where the lock state and the target word interact. Examples are a locked write to the configuration word, a re-lock by a near-miss key, and a status word written while open and then probed after closing. Directed phases step through closed, open and closed again, each with writes to the special words. A pseudo-random phase then mixes key writes, wrong keys, out-of-window offsets and unaligned addresses, so the lock flips many times between ordinary writes. Two instances share the stimulus: one uses variant B with a mapped size, the other uses variant A with an unsupported size that exercises the fallback.

// File: rtl/dramcfg_pkg.sv
// Package: shared constants, the variant type and the functions that build
// the protected mask, the constant pattern and the size code.
// Assumes 32-bit words; the word indices below are part of the behaviour.
package dramcfg_pkg;

    localparam int unsigned WORD_W = 32;

    // Unlock key for the lock word
    localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hFC60_0309;

    // Word indices with special handling
    localparam int unsigned PROT_IDX = 0;
    localparam int unsigned CONF_IDX = 1;
    localparam int unsigned PHY_IDX  = 24;
    localparam int unsigned TEST_IDX = 28;

    // Bit positions inside the special words
    localparam int unsigned SIZE_LSB       = 0;
    localparam int unsigned APER_LSB       = 2;
    localparam int unsigned DISPLAY_BIT    = 6;
    localparam int unsigned A_RSVD_LSB     = 11;
    localparam int unsigned B_RSVD_LSB     = 14;
    localparam int unsigned B_RSVD_MSB     = 18;
    localparam int unsigned B_INITDONE_BIT = 19;
    localparam int unsigned B_VER_LSB      = 28;
    localparam int unsigned PHY_BUSY_BIT   = 0;
    localparam int unsigned TEST_DONE_BIT  = 12;
    localparam int unsigned TEST_FAIL_BIT  = 13;

    typedef enum logic {VAR_A = 1'b0, VAR_B = 1'b1} variant_e;

    // Map the installed size in MB to the 2-bit code; unknown sizes fall back
    function automatic logic [1:0] size_code(input variant_e v, input int unsigned mb);
        logic [1:0] c;
        if (v == VAR_A) begin
            case (mb)
                64:      c = 2'd0;
                128:     c = 2'd1;
                256:     c = 2'd2;
                512:     c = 2'd3;
                default: c = 2'd2;
            endcase
        end else begin
            case (mb)
                128:     c = 2'd0;
                256:     c = 2'd1;
                512:     c = 2'd2;
                1024:    c = 2'd3;
                default: c = 2'd2;
            endcase
        end
        return c;
    endfunction

    // Bits of the configuration word that software cannot change
    function automatic logic [WORD_W-1:0] ro_mask(input variant_e v);
        logic [WORD_W-1:0] m;
        m = '0;
        m[APER_LSB +: 2] = 2'b11;
        m[DISPLAY_BIT]   = 1'b1;
        if (v == VAR_A) begin
            m[WORD_W-1:A_RSVD_LSB] = '1;
        end else begin
            m[B_VER_LSB +: 4]            = 4'hF;
            m[B_INITDONE_BIT]            = 1'b1;
            m[B_RSVD_MSB:B_RSVD_LSB]     = '1;
        end
        return m;
    endfunction

    // Constant pattern merged into every configuration write and loaded on reset
    function automatic logic [WORD_W-1:0] fixed_bits(input variant_e v, input int unsigned mb);
        logic [WORD_W-1:0] f;
        f = '0;
        f[SIZE_LSB +: 2] = size_code(v, mb);
        if (v == VAR_A) begin
            f[DISPLAY_BIT] = 1'b1;
        end else begin
            f[B_VER_LSB +: 4] = 4'd1;
            f[APER_LSB +: 2]  = 2'd3;
            f[B_INITDONE_BIT] = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/dramcfg_addr_dec.sv
// Address decoder: turns a byte address into a one-hot word select and an
// in-range flag. Assumes word-aligned use; bits 1:0 are ignored.
module dramcfg_addr_dec #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                in_range
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [IDX_W:0] LIMIT = NUM_REGS[IDX_W:0];

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lsb;

    // Word index: drop byte-lane bits
    always_comb begin
        idx        = addr[ADDR_W-1:2];
        unused_lsb = addr[1:0];
    end

    // Range check against implemented word count
    always_comb in_range = ({1'b0, idx} < LIMIT);

    // One select line per implemented word
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = (idx == IDX_W'(i));
    end

    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    a_r8_no_sel_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (sel == '0));
endmodule

// File: rtl/dramcfg_wr_shape.sv
// Write-data shaper: produces the value to store for the addressed word.
// Lock word gets a key-match flag, configuration word gets mask/pattern merge,
// and in variant B the two status words get their forced bits.
// Assumes at most one hit_* input is high at a time.
module dramcfg_wr_shape
    import dramcfg_pkg::*;
#(
    parameter variant_e    VARIANT = VAR_B,
    parameter int unsigned MEM_MB  = 512
) (
    input  logic [WORD_W-1:0] raw,
    input  logic              hit_prot,
    input  logic              hit_conf,
    input  logic              hit_phy,
    input  logic              hit_test,
    output logic [WORD_W-1:0] shaped
);
    localparam logic [WORD_W-1:0] MASK = ro_mask(VARIANT);
    localparam logic [WORD_W-1:0] FIX  = fixed_bits(VARIANT, MEM_MB);

    logic [WORD_W-1:0] after_conf;
    logic [WORD_W-1:0] after_stat;

    // Merge protected fields of the configuration word
    always_comb after_conf = hit_conf ? ((raw & ~MASK) | FIX) : raw;

    if (VARIANT == VAR_B) begin : g_status
        // Force the status words to report success
        always_comb begin
            after_stat = after_conf;
            if (hit_phy) after_stat[PHY_BUSY_BIT] = 1'b0;
            if (hit_test) begin
                after_stat[TEST_DONE_BIT] = 1'b1;
                after_stat[TEST_FAIL_BIT] = 1'b0;
            end
        end
    end else begin : g_plain
        logic unused_hits;
        // Variant A stores status words as written
        always_comb begin
            after_stat  = after_conf;
            unused_hits = hit_phy ^ hit_test;
        end
    end

    // Lock word stores only whether the key matched
    always_comb shaped = hit_prot ? WORD_W'(raw == UNLOCK_KEY) : after_stat;
endmodule

// File: rtl/dramcfg_store.sv
// Word storage: one register per word with its own write enable.
// Synchronous active-low reset clears all words except RST_IDX, which loads
// RST_WORD. Assumes the enables are already gated by the lock.
module dramcfg_store
    import dramcfg_pkg::*;
#(
    parameter int unsigned       NUM_REGS = 32,
    parameter int unsigned       RST_IDX  = 1,
    parameter logic [WORD_W-1:0] RST_WORD = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REGS-1:0]             we,
    input  logic [WORD_W-1:0]               wdata,
    output logic [NUM_REGS-1:0][WORD_W-1:0] words
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        localparam logic [WORD_W-1:0] INIT = (i == RST_IDX) ? RST_WORD : '0;

        // Hold or update one word
        always_ff @(posedge clk) begin
            if (!rst_n)     words[i] <= INIT;
            else if (we[i]) words[i] <= wdata;
        end

        a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            we[i] |=> (words[i] == $past(wdata)));
        a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !we[i] |=> $stable(words[i]));
    end
endmodule

// File: rtl/dramcfg_keyed_regs.sv
// Top: key-protected configuration register bank for a DRAM controller.
// Decodes the address, gates writes with the lock word, shapes the write
// data per word and variant, stores it, and returns reads combinationally.
// Assumes single-cycle 32-bit accesses; bus_addr bits 1:0 are ignored.
module dramcfg_keyed_regs
    import dramcfg_pkg::*;
#(
    parameter variant_e    VARIANT  = VAR_B,
    parameter int unsigned MEM_MB   = 512,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    localparam logic [WORD_W-1:0] CONF_MASK = ro_mask(VARIANT);
    localparam logic [WORD_W-1:0] CONF_FIX  = fixed_bits(VARIANT, MEM_MB);

    logic [NUM_REGS-1:0]             sel;
    logic                            in_range;
    logic [NUM_REGS-1:0]             we;
    logic [WORD_W-1:0]               shaped;
    logic [NUM_REGS-1:0][WORD_W-1:0] words;
    logic                            lock_open;

    dramcfg_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .sel      (sel),
        .in_range (in_range)
    );

    dramcfg_wr_shape #(.VARIANT(VARIANT), .MEM_MB(MEM_MB)) u_shape (
        .raw      (bus_wdata),
        .hit_prot (sel[PROT_IDX]),
        .hit_conf (sel[CONF_IDX]),
        .hit_phy  (sel[PHY_IDX]),
        .hit_test (sel[TEST_IDX]),
        .shaped   (shaped)
    );

    // Lock state is bit 0 of the lock word
    always_comb lock_open = words[PROT_IDX][0];

    // Write enables: lock word always writable, others only when open
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
        if (i == PROT_IDX) begin : g_key
            assign we[i] = bus_wr & sel[i];
        end else begin : g_gated
            assign we[i] = bus_wr & sel[i] & lock_open;
        end
    end

    dramcfg_store #(.NUM_REGS(NUM_REGS), .RST_IDX(CONF_IDX), .RST_WORD(CONF_FIX)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wdata (shaped),
        .words (words)
    );

    // AND-OR read mux over the one-hot select
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) bus_rdata = bus_rdata | words[i];
        end
    end

    a_r1_key_sets_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel[PROT_IDX]) |=> (lock_open == ($past(bus_wdata) == UNLOCK_KEY)));
    a_r2_lock_word_binary: assert property (@(posedge clk) disable iff (!rst_n)
        words[PROT_IDX][WORD_W-1:1] == '0);
    a_r3_locked_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !lock_open && !sel[PROT_IDX]) |=> $stable(words));
    a_r4_conf_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (words[CONF_IDX] & CONF_MASK) == (CONF_FIX & CONF_MASK));
    a_r4_conf_pattern_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (words[CONF_IDX] & CONF_FIX) == CONF_FIX);
    a_r8_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (bus_rdata == '0));

    if (VARIANT == VAR_B) begin : g_chk_b
        a_r6_phy_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
            words[PHY_IDX][PHY_BUSY_BIT] == 1'b0);
        a_r7_test_passes: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && lock_open && sel[TEST_IDX]) |=>
            (words[TEST_IDX][TEST_FAIL_BIT:TEST_DONE_BIT] == 2'b01));
    end
endmodule

// File: tb/dramcfg_keyed_regs_test.sv
// Bench: two instances (variant B at 1024 MB, variant A at an unsupported
// size) share one bus; a behavioural model predicts each read every cycle.
module dramcfg_keyed_regs_test;
    import dramcfg_pkg::*;

    localparam int          NREG   = 32;
    localparam logic [31:0] KEY    = 32'hFC60_0309;
    localparam logic [31:0] A_MASK = 32'hFFFF_F84C;
    localparam logic [31:0] A_FIX  = 32'h0000_0042;
    localparam logic [31:0] B_MASK = 32'hF00F_C04C;
    localparam logic [31:0] B_FIX  = 32'h1008_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_b, rd_a;

    always #4 clk = ~clk;

    dramcfg_keyed_regs #(.VARIANT(VAR_B), .MEM_MB(1024)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b));

    dramcfg_keyed_regs #(.VARIANT(VAR_A), .MEM_MB(100)) uut_a (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_a));

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [31:0] mdl_a [NREG];
    logic [31:0] mdl_b [NREG];

    function automatic logic [31:0] peek(bit is_b, logic [11:0] a);
        int i = int'(a[11:2]);
        if (i >= NREG) return 32'h0;
        return is_b ? mdl_b[i] : mdl_a[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) begin
            mdl_a[i] = '0;
            mdl_b[i] = '0;
        end
        mdl_a[1] = A_FIX;
        mdl_b[1] = B_FIX;
    endtask

    task automatic model_write(bit is_b, logic [11:0] a, logic [31:0] d);
        int i = int'(a[11:2]);
        logic [31:0] v = d;
        if (i >= NREG) return;
        if (i == 0) begin
            if (is_b) mdl_b[0] = (d == KEY) ? 32'd1 : 32'd0;
            else      mdl_a[0] = (d == KEY) ? 32'd1 : 32'd0;
            return;
        end
        if ((is_b ? mdl_b[0] : mdl_a[0]) == 32'd0) return;
        if (i == 1) v = is_b ? ((v & ~B_MASK) | B_FIX) : ((v & ~A_MASK) | A_FIX);
        if (is_b && i == 24) v[0] = 1'b0;
        if (is_b && i == 28) begin
            v[12] = 1'b1;
            v[13] = 1'b0;
        end
        if (is_b) mdl_b[i] = v;
        else      mdl_a[i] = v;
    endtask

    task automatic check(string req, string who, logic [11:0] a, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s inst=%s addr=%h actual=%h expected=%h", req, who, a, got, exp);
        end
    endtask

    // One bus cycle: drive after negedge, compare reads, then advance model at the edge
    task automatic step(string req, bit wr, logic [11:0] a, logic [31:0] d);
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = d;
        #1;
        check(req, "B", a, rd_b, peek(1'b1, a));
        check(req, "A", a, rd_a, peek(1'b0, a));
        @(posedge clk);
        if (wr) begin
            model_write(1'b1, a, d);
            model_write(1'b0, a, d);
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R11 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'h1D2C_3B4A;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 reset values, R8 outside the implemented words
        for (int i = 0; i < 36; i++) step(i < NREG ? "R5" : "R8", 1'b0, 12'(i * 4), '0);

        // R9 size codes: B at 1024 MB -> 3, A at unsupported size -> 2
        bus_addr = 12'h004;
        #1;
        check("R9", "B", 12'h004, {30'b0, rd_b[1:0]}, 32'd3);
        check("R9", "A", 12'h004, {30'b0, rd_a[1:0]}, 32'd2);
        @(negedge clk);

        // R3 writes while locked
        step("R3", 1'b1, 12'h004, 32'hFFFF_FFFF);
        step("R3", 1'b1, 12'h008, 32'h0000_1234);
        step("R3", 1'b0, 12'h004, '0);
        step("R3", 1'b0, 12'h008, '0);

        // R2 near-miss key, R1 correct key
        step("R2", 1'b1, 12'h000, 32'hFC60_0308);
        step("R2", 1'b0, 12'h000, '0);
        step("R1", 1'b1, 12'h000, KEY);
        step("R1", 1'b0, 12'h000, '0);

        // R4 configuration merge
        step("R4", 1'b1, 12'h004, 32'hFFFF_FFFF);
        step("R4", 1'b0, 12'h004, '0);
        step("R4", 1'b1, 12'h004, 32'h0000_0000);
        step("R4", 1'b0, 12'h004, '0);
        step("R4", 1'b1, 12'h004, 32'h5A5A_07B1);
        step("R4", 1'b0, 12'h004, '0);

        // R11 plain words, R6/R7 status words
        for (int i = 2; i < NREG; i++) step("R11", 1'b1, 12'(i * 4), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
        for (int i = 2; i < NREG; i++) step("R11", 1'b0, 12'(i * 4), '0);
        step("R6", 1'b1, 12'h060, 32'hFFFF_FFFF);
        step("R6", 1'b0, 12'h060, '0);
        step("R7", 1'b1, 12'h070, 32'h0000_2000);
        step("R7", 1'b0, 12'h070, '0);
        step("R7", 1'b1, 12'h070, 32'hFFFF_FFFF);
        step("R7", 1'b0, 12'h070, '0);

        // R10 unaligned addresses
        step("R10", 1'b1, 12'h017, 32'hCAFE_0001);
        step("R10", 1'b0, 12'h014, '0);
        step("R10", 1'b0, 12'h016, '0);

        // R8 writes outside the implemented words
        step("R8", 1'b1, 12'h800, 32'hDEAD_BEEF);
        step("R8", 1'b1, 12'hFFC, 32'hFFFF_FFFF);
        step("R8", 1'b1, 12'h080, 32'h1234_5678);
        step("R8", 1'b0, 12'h800, '0);
        step("R8", 1'b0, 12'hFFC, '0);
        step("R8", 1'b0, 12'h080, '0);
        for (int i = 0; i < NREG; i++) step("R8", 1'b0, 12'(i * 4), '0);

        // R2 relock, then R3 locked writes
        step("R2", 1'b1, 12'h000, 32'h0000_0000);
        step("R3", 1'b1, 12'h014, 32'h0);
        step("R3", 1'b1, 12'h004, 32'h0);
        step("R3", 1'b1, 12'h070, 32'h0);
        step("R3", 1'b0, 12'h014, '0);
        step("R3", 1'b0, 12'h004, '0);
        step("R3", 1'b0, 12'h070, '0);
        step("R2", 1'b0, 12'h000, '0);

        // Mixed pseudo-random traffic
        for (int n = 0; n < 2000; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {5'b0, lfsr[4:0], lfsr[12:11]};
            if (lfsr[9:8] == 2'b11) a[11] = 1'b1;
            if (lfsr[16:14] == 3'b000) a = {10'b0, lfsr[18:17]};
            d = {lfsr[15:0], lfsr[31:16]};
            if (a[11:2] == 10'd0 && lfsr[5]) d = KEY;
            step("R11", lfsr[10], a, d);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule